// File: doc/BRIEF.md
# Register-Register Synchronous SRAM with Pipelined Deselect

This block is a single-port synchronous SRAM with a two-edge read pipeline. A read command and its address are registered on one rising clock edge. The array word is loaded into an output register on the following edge, and that register drives the data bus. A deselect (select high) passes through the same two-edge pipeline. The bus therefore keeps the previous read word for one more cycle and is released only one edge after the deselect was sampled.

Writes use a late-data scheme. The command and address are sampled on one edge. The write data and the active-low per-lane write enables are sampled on the next edge into a holding register, and the array is updated from that register on the edge after. A read that arrives while a write is still in the holding register returns the new data for the enabled lanes. The data bus is modelled as separate input, output and output-enable signals. The output enable is gated by an active-low output-enable pin and by an active-high sleep pin. While sleep is high, new commands are also ignored.

Top module: `sram_rr_pipe`

## Requirements
- R1: A read command (sel_n=0, wr_n=1, sleep=0) sampled at edge N makes dout equal the addressed word after edge N+1. dout_en is 1 if oe_n=0 and sleep=0.
- R2: Reads sampled on consecutive edges produce a new word after every edge, with no idle cycle. dout does not change after an edge whose previous command was not a read.
- R3: A deselect (sel_n=1) sampled at edge N leaves the output of the earlier read driven after edge N. dout_en is 0 after edge N+1.
- R4: dout_en is 0 whenever oe_n=1. Lowering oe_n again drives the held word without a new command.
- R5: The word is split into lanes of LANE_W bits, with lane 0 in the low bits. A write updates lane k only when lane_wr_n[k]=0, and leaves the other lanes unchanged.
- R6: Write data and lane enables are taken from din and lane_wr_n at the edge after the write command. Their values at the command edge have no effect.
- R7: A read sampled on the same edge as a write's data phase, to the same address, returns the newly written lanes merged with the old word.
- R8: While sleep=1, read and write commands are ignored and dout_en is 0.
- R9: A write command (sel_n=0, wr_n=0) sampled at edge N gives dout_en=0 after edge N+1.
- R10: A synchronous active-high rst clears the pipeline to the deselected state, so dout_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Word address, sampled with the command |
| sel_n | input | 1 | Select, active low |
| wr_n | input | 1 | Write enable, active low |
| lane_wr_n | input | LANES | Per-lane write enables, active low, sampled in the data phase |
| oe_n | input | 1 | Output enable, active low |
| sleep | input | 1 | Sleep, active high |
| din | input | LANES*LANE_W | Write data, sampled in the data phase |
| dout | output | LANES*LANE_W | Registered read data |
| dout_en | output | 1 | Drive enable for the data bus |

## Verification
A single pattern of reads is not enough, so the main read path is tried with several. Reads separated by deselects show whether the word lands on the second edge. Back-to-back reads of different addresses show whether the pipeline stalls or repeats a word. A read followed by two deselects tells a release delayed by one edge apart from an immediate one. Full and partial lane writes, each followed at once by a read of the same address, show whether the holding-register forwarding merges lanes correctly. Wrong data placed at the command edge exposes data sampled one edge too early. Commands issued under sleep, and oe_n toggled while a word is held, separate command blocking from plain output gating.

// File: rtl/sram_rr_pkg.sv
package sram_rr_pkg;

    localparam int DEF_ADDR_W = 8;
    localparam int DEF_LANES  = 2;
    localparam int DEF_LANE_W = 9;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2
    } cmd_e;

    // Sleep or a high select both turn the edge into a no-operation.
    function automatic cmd_e decode_cmd(input logic sel_n, input logic wr_n,
                                        input logic sleep);
        if (sleep || sel_n) return CMD_NONE;
        return wr_n ? CMD_READ : CMD_WRITE;
    endfunction

endpackage

// File: rtl/sram_rr_cmd_stage.sv
module sram_rr_cmd_stage
    import sram_rr_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic              sleep,
    input  logic [ADDR_W-1:0] addr,
    output cmd_e              cmd_q,
    output logic [ADDR_W-1:0] addr_q
);

    typedef struct packed {
        cmd_e              cmd;
        logic [ADDR_W-1:0] addr;
    } stage_t;

    stage_t stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q.cmd  <= CMD_NONE;
            stage_q.addr <= '0;
        end else begin
            stage_q.cmd  <= decode_cmd(sel_n, wr_n, sleep);
            stage_q.addr <= addr;
        end
    end

    assign cmd_q  = stage_q.cmd;
    assign addr_q = stage_q.addr;

endmodule

// File: rtl/sram_rr_wr_hold.sv
module sram_rr_wr_hold
    import sram_rr_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int LANES  = DEF_LANES,
    parameter int LANE_W = DEF_LANE_W,
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_e              cmd,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [WORD_W-1:0] din,
    input  logic [LANES-1:0]  lane_wr_n,
    output logic              hold_vld,
    output logic [ADDR_W-1:0] hold_addr,
    output logic [WORD_W-1:0] hold_data,
    output logic [LANES-1:0]  hold_mask
);

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
        logic [LANES-1:0]  mask;
    } hold_t;

    hold_t hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (cmd == CMD_WRITE) begin
            hold_q.vld  <= 1'b1;
            hold_q.addr <= cmd_addr;
            hold_q.data <= din;
            hold_q.mask <= ~lane_wr_n;
        end else begin
            hold_q.vld <= 1'b0;
        end
    end

    assign hold_vld  = hold_q.vld;
    assign hold_addr = hold_q.addr;
    assign hold_data = hold_q.data;
    assign hold_mask = hold_q.mask;

endmodule

// File: rtl/sram_rr_array.sv
module sram_rr_array
    import sram_rr_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int LANES  = DEF_LANES,
    parameter int LANE_W = DEF_LANE_W,
    localparam int WORD_W = LANES * LANE_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [LANES-1:0]  wr_mask,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);

    // One bank per lane keeps every lane write in its own process.
    for (genvar l = 0; l < LANES; l++) begin : g_bank
        logic [LANE_W-1:0] bank [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_mask[l]) begin
                bank[wr_addr] <= wr_data[l*LANE_W +: LANE_W];
            end
        end

        assign rd_data[l*LANE_W +: LANE_W] = bank[rd_addr];
    end

endmodule

// File: rtl/sram_rr_out_stage.sv
module sram_rr_out_stage
    import sram_rr_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int LANES  = DEF_LANES,
    parameter int LANE_W = DEF_LANE_W,
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_e              cmd,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [WORD_W-1:0] mem_data,
    input  logic              hold_vld,
    input  logic [ADDR_W-1:0] hold_addr,
    input  logic [WORD_W-1:0] hold_data,
    input  logic [LANES-1:0]  hold_mask,
    input  logic              oe_n,
    input  logic              sleep,
    output logic [WORD_W-1:0] dout,
    output logic              dout_en
);

    logic              hit;
    logic [WORD_W-1:0] fwd_word;
    logic [WORD_W-1:0] dout_q;
    logic              valid_q;

    assign hit = hold_vld && (hold_addr == rd_addr);

    for (genvar l = 0; l < LANES; l++) begin : g_fwd
        assign fwd_word[l*LANE_W +: LANE_W] = (hit && hold_mask[l])
            ? hold_data[l*LANE_W +: LANE_W]
            : mem_data[l*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            dout_q  <= '0;
        end else begin
            valid_q <= (cmd == CMD_READ);
            if (cmd == CMD_READ) dout_q <= fwd_word;
        end
    end

    assign dout    = dout_q;
    assign dout_en = valid_q && !oe_n && !sleep;

    // R2: the output word only moves on an edge that completes a read
    assert_hold_word_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd != CMD_READ) |=> $stable(dout_q));

    // R4 / R8: gating pins always silence the bus
    assert_gate_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (oe_n || sleep) |-> !dout_en);

endmodule

// File: rtl/sram_rr_pipe.sv
module sram_rr_pipe
    import sram_rr_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int LANES  = DEF_LANES,
    parameter int LANE_W = DEF_LANE_W,
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic              oe_n,
    input  logic              sleep,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout,
    output logic              dout_en
);

    cmd_e              st_cmd;
    logic [ADDR_W-1:0] st_addr;
    logic              hold_vld;
    logic [ADDR_W-1:0] hold_addr;
    logic [WORD_W-1:0] hold_data;
    logic [LANES-1:0]  hold_mask;
    logic [WORD_W-1:0] mem_data;

    sram_rr_cmd_stage #(.ADDR_W(ADDR_W)) u_cmd (
        .clk    (clk),
        .rst    (rst),
        .sel_n  (sel_n),
        .wr_n   (wr_n),
        .sleep  (sleep),
        .addr   (addr),
        .cmd_q  (st_cmd),
        .addr_q (st_addr)
    );

    sram_rr_wr_hold #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .cmd       (st_cmd),
        .cmd_addr  (st_addr),
        .din       (din),
        .lane_wr_n (lane_wr_n),
        .hold_vld  (hold_vld),
        .hold_addr (hold_addr),
        .hold_data (hold_data),
        .hold_mask (hold_mask)
    );

    sram_rr_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .wr_en   (hold_vld),
        .wr_addr (hold_addr),
        .wr_data (hold_data),
        .wr_mask (hold_mask),
        .rd_addr (st_addr),
        .rd_data (mem_data)
    );

    sram_rr_out_stage #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .cmd       (st_cmd),
        .rd_addr   (st_addr),
        .mem_data  (mem_data),
        .hold_vld  (hold_vld),
        .hold_addr (hold_addr),
        .hold_data (hold_data),
        .hold_mask (hold_mask),
        .oe_n      (oe_n),
        .sleep     (sleep),
        .dout      (dout),
        .dout_en   (dout_en)
    );

    // R1: a read lands on the bus two edges after it is sampled
    assert_read_lands_R1: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && wr_n && !sleep) |=> ##1 (dout_en || oe_n || sleep));

    // R3: a deselect releases the bus one edge late, never later
    assert_desel_release_R3: assert property (@(posedge clk) disable iff (rst)
        sel_n |=> ##1 !dout_en);

    // R9: a write command leaves the bus released in its data phase
    assert_write_release_R9: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && !wr_n) |=> ##1 !dout_en);

endmodule

// File: tb/sram_rr_pipe_test.sv
`timescale 1ns/100ps
module sram_rr_pipe_test;

    localparam int AW = 8;
    localparam int WW = 18;
    localparam int NV = 26;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          sel_n = 1'b1;
    logic          wr_n = 1'b1;
    logic [1:0]    lane_wr_n = 2'b11;
    logic          oe_n = 1'b0;
    logic          sleep = 1'b0;
    logic [WW-1:0] din = '0;
    logic [WW-1:0] dout;
    logic          dout_en;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    sram_rr_pipe uut (
        .clk(clk), .rst(rst), .addr(addr), .sel_n(sel_n), .wr_n(wr_n),
        .lane_wr_n(lane_wr_n), .oe_n(oe_n), .sleep(sleep), .din(din),
        .dout(dout), .dout_en(dout_en)
    );

    typedef struct packed {
        logic          s;
        logic          w;
        logic [1:0]    be;
        logic          o;
        logic          sl;
        logic [AW-1:0] a;
        logic [WW-1:0] d;
        logic          xdrv;
        logic [WW-1:0] xd;
        logic [3:0]    req;
    } vec_t;

    // Each row: inputs for one edge, expected bus state just after it.
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b0,2'b11,1'b0,1'b0,8'd10,18'h3FFFF,1'b0,18'h0,4'd10},    // R10 write 10, junk data
        '{1'b1,1'b1,2'b00,1'b0,1'b0,8'd0 ,18'h12345,1'b0,18'h0,4'd9},     // R9 data phase
        '{1'b0,1'b0,2'b11,1'b0,1'b0,8'd20,18'h3FFFF,1'b0,18'h0,4'd3},     // write 20
        '{1'b0,1'b1,2'b00,1'b0,1'b0,8'd20,18'h0ABCD,1'b0,18'h0,4'd9},     // R9 read 20 + data
        '{1'b0,1'b1,2'b11,1'b0,1'b0,8'd10,18'h0    ,1'b1,18'h0ABCD,4'd7}, // R7 forwarded
        '{1'b0,1'b1,2'b11,1'b0,1'b0,8'd20,18'h0    ,1'b1,18'h12345,4'd6}, // R6 junk ignored
        '{1'b1,1'b1,2'b11,1'b0,1'b0,8'd0 ,18'h0    ,1'b1,18'h0ABCD,4'd3}, // R3 still driven
        '{1'b1,1'b1,2'b11,1'b0,1'b0,8'd0 ,18'h0    ,1'b0,18'h0,4'd3},     // R3 released
        '{1'b0,1'b0,2'b11,1'b0,1'b0,8'd10,18'h0    ,1'b0,18'h0,4'd9},
        '{1'b0,1'b1,2'b10,1'b0,1'b0,8'd10,18'h3FFFF,1'b0,18'h0,4'd9},     // lane 0 only
        '{1'b0,1'b1,2'b11,1'b0,1'b0,8'd10,18'h0    ,1'b1,18'h123FF,4'd7}, // R7 partial merge
        '{1'b0,1'b1,2'b11,1'b1,1'b0,8'd10,18'h0    ,1'b0,18'h0,4'd4},     // R4 gated
        '{1'b1,1'b1,2'b11,1'b0,1'b0,8'd0 ,18'h0    ,1'b1,18'h123FF,4'd4}, // R4 restored
        '{1'b0,1'b0,2'b11,1'b0,1'b0,8'd20,18'h0    ,1'b0,18'h0,4'd3},
        '{1'b1,1'b1,2'b01,1'b0,1'b0,8'd0 ,18'h0    ,1'b0,18'h0,4'd9},     // lane 1 only
        '{1'b0,1'b1,2'b11,1'b0,1'b0,8'd20,18'h0    ,1'b0,18'h0,4'd3},
        '{1'b1,1'b1,2'b11,1'b0,1'b0,8'd0 ,18'h0    ,1'b1,18'h001CD,4'd5}, // R5 lane kept
        '{1'b0,1'b1,2'b11,1'b0,1'b1,8'd10,18'h0    ,1'b0,18'h0,4'd8},     // R8 read in sleep
        '{1'b1,1'b1,2'b11,1'b0,1'b0,8'd0 ,18'h0    ,1'b0,18'h0,4'd8},
        '{1'b0,1'b0,2'b11,1'b0,1'b1,8'd20,18'h0    ,1'b0,18'h0,4'd8},     // R8 write in sleep
        '{1'b1,1'b1,2'b00,1'b0,1'b0,8'd0 ,18'h3FFFF,1'b0,18'h0,4'd8},
        '{1'b0,1'b1,2'b11,1'b0,1'b0,8'd20,18'h0    ,1'b0,18'h0,4'd8},
        '{1'b1,1'b1,2'b11,1'b0,1'b0,8'd0 ,18'h0    ,1'b1,18'h001CD,4'd8}, // R8 no write done
        '{1'b0,1'b1,2'b11,1'b0,1'b0,8'd20,18'h0    ,1'b0,18'h0,4'd3},
        '{1'b1,1'b1,2'b11,1'b0,1'b1,8'd0 ,18'h0    ,1'b0,18'h0,4'd8},     // R8 sleep releases
        '{1'b1,1'b1,2'b11,1'b0,1'b0,8'd0 ,18'h0    ,1'b0,18'h0,4'd3}
    };

    task automatic check(input logic xdrv, input logic [WW-1:0] xd, input int req);
        n_checks++;
        if (dout_en !== xdrv || (xdrv && dout !== xd)) begin
            n_fails++;
            $display("FAIL R%0d: actual en=%0b data=%h expected en=%0b data=%h",
                     req, dout_en, dout, xdrv, xd);
        end
    endtask

    // Drive at the falling edge, sample 1 ns after the rising edge.
    task automatic step(input logic s, input logic w, input logic [1:0] be,
                        input logic o, input logic sl, input logic [AW-1:0] a,
                        input logic [WW-1:0] d);
        @(negedge clk);
        sel_n = s; wr_n = w; lane_wr_n = be; oe_n = o; sleep = sl; addr = a; din = d;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [WW-1:0] pat(input int a);
        return WW'(a * 1237 + 91);
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(1'b0, '0, 10);                    // R10 reset state
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].s, VEC[i].w, VEC[i].be, VEC[i].o, VEC[i].sl, VEC[i].a, VEC[i].d);
            check(VEC[i].xdrv, VEC[i].xd, int'(VEC[i].req));
        end

        // R2: four writes, then four reads on consecutive edges
        for (int a = 40; a < 44; a++) begin
            step(1'b0, 1'b0, 2'b11, 1'b0, 1'b0, AW'(a), '0);
            step(1'b1, 1'b1, 2'b00, 1'b0, 1'b0, '0, pat(a));
        end
        step(1'b0, 1'b1, 2'b11, 1'b0, 1'b0, AW'(40), '0);
        for (int a = 41; a < 44; a++) begin
            step(1'b0, 1'b1, 2'b11, 1'b0, 1'b0, AW'(a), '0);
            check(1'b1, pat(a - 1), 2);         // R2 new word each edge
        end
        step(1'b1, 1'b1, 2'b11, 1'b0, 1'b0, '0, '0);
        check(1'b1, pat(43), 1);                // R1 last read lands

        // R10: reset asserted while a read is in flight
        step(1'b0, 1'b1, 2'b11, 1'b0, 1'b0, AW'(41), '0);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check(1'b0, '0, 10);                    // R10 pipeline cleared
        @(negedge clk);
        rst = 1'b0;
        sel_n = 1'b1;
        @(posedge clk);
        #1;
        check(1'b0, '0, 10);                    // R10 flushed read never appears

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog (all requirements): actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule